// File: doc/BRIEF.md
# Page-mode static RAM read sequencer

This block reads one 16-byte page from an asynchronous page-mode static RAM. A requester supplies a page address, a bus-width code and three timing and lane settings: the wait count of the first access in each group of four, the wait count of the other accesses, and a byte-lane policy bit. The block then holds chip select and output enable low and steps the external address through the page. On the last clock of each access it captures the read data and returns it with a one-cycle strobe and the access index.

A 32-bit bus needs four accesses per page, a 16-bit bus eight and an 8-bit bus sixteen. Accesses come in groups of four. The first access of a group is longer, and the other three use the shorter page wait. A new request is accepted only when the block reports ready. Ready is low for the whole of a page.

Top module: `pgsram_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n, mem_oe_n and every bit of mem_be_n are 1, and rd_valid and done are 0.
- R2: A page makes 4 accesses when req_width is 2'b00 (32-bit), 8 when it is 2'b01 (16-bit) and 16 when it is 2'b10 (8-bit). rd_index counts 0, 1, 2 and upward by one.
- R3: Access k lasts req_first_wait+1 clocks when k mod 4 is 0, and req_page_wait+1 clocks otherwise.
- R4: The page base is req_addr with its low 4 bits forced to zero. During access k, mem_addr equals base + k*B, where B is 4, 2 or 1 bytes for the 32-, 16- or 8-bit width.
- R5: mem_cs_n and mem_oe_n are 0 in every clock from the first clock of access 0 through the last clock of the final access, and 1 in the clock after it.
- R6: With the policy bit at 1, mem_be_n is 4'b0000 in every access clock. With it at 0, mem_be_n stays 4'b1111.
- R7: On the last clock of access k the block samples mem_rdata. In the next clock it shows rd_valid=1, rd_data equal to that sample and rd_index=k. rd_valid is 0 in every other clock.
- R8: done is 1 for exactly one clock, the clock in which the final access's rd_valid appears. req_ready is 1 again in that clock.
- R9: req_ready is 0 for the whole page. A req_valid raised with a different address during a page has no effect on that page's addresses.
- R10: A req_width of 2'b11 behaves as the 8-bit width (16 accesses, 1-byte steps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Page request |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | AW | Page address (low 4 bits ignored) |
| req_width | input | 2 | Bus width: 00=32, 01=16, 1x=8 bits |
| req_first_wait | input | WW | Wait count for the first access of each group |
| req_page_wait | input | WW | Wait count for the other accesses |
| req_lane_pol | input | 1 | 1: drive byte lanes low during reads |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 4 | Byte lanes, active low |
| mem_addr | output | AW | Byte address to the memory |
| mem_rdata | input | DW | Read data from the memory |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DW | Captured read data |
| rd_index | output | 4 | Access index within the page |
| done | output | 1 | Page finished |

## Verification
Zero wait counts are the sharpest corner. In that case every access lasts one clock, so a counter that reloads off by one would stretch each access or merge two of them, and the per-clock address checks would catch it. Unequal first and page waits on 16- and 8-bit widths show whether the long access recurs at every fourth access or appears only once. An unaligned request address and an address near the top of the range show whether the low bits leak into the base. The bench raises a second request in the middle of a page to show that a design taking it early would jump address. It also runs width code 2'b11 to show that this code is not taken as the 32-bit width.

// File: rtl/pgsram_rd_seq.sv
module pgsram_rd_seq #(
  parameter int AW = 28,
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_width,
  input  logic [WW-1:0] req_first_wait,
  input  logic [WW-1:0] req_page_wait,
  input  logic          req_lane_pol,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic [3:0]    mem_be_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [3:0]    rd_index,
  output logic          done
);
  localparam int IW = 4;

  logic          busy;
  logic [IW-1:0] idx, last_idx, nidx;
  logic [WW-1:0] cnt, first_q, page_q;
  logic [AW-1:0] base_q, step;
  logic [1:0]    wid_q;
  logic          pol_q;
  logic          accept;

  assign accept    = req_valid & ~busy;
  assign req_ready = ~busy;
  assign mem_cs_n  = ~busy;
  assign mem_oe_n  = ~busy;
  assign mem_be_n  = (busy & pol_q) ? 4'b0000 : 4'b1111;
  assign mem_addr  = base_q + step;
  assign nidx      = idx + 1'b1;

  always_comb begin
    case (wid_q)
      2'b00: begin last_idx = 4'd3;  step = AW'(idx) << 2; end
      2'b01: begin last_idx = 4'd7;  step = AW'(idx) << 1; end
      default: begin last_idx = 4'd15; step = AW'(idx); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      first_q  <= '0;
      page_q   <= '0;
      base_q   <= '0;
      wid_q    <= 2'b00;
      pol_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_index <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (accept) begin
        base_q  <= {req_addr[AW-1:4], 4'b0000};
        wid_q   <= req_width;
        first_q <= req_first_wait;
        page_q  <= req_page_wait;
        pol_q   <= req_lane_pol;
        idx     <= '0;
        cnt     <= req_first_wait;
        busy    <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          rd_valid <= 1'b1;
          rd_data  <= mem_rdata;
          rd_index <= idx;
          if (idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= nidx;
            cnt <= (nidx[1:0] == 2'b00) ? first_q : page_q;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  a_r4_addr_held_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cnt) != '0) |-> $stable(mem_addr));

  a_r2_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && idx != $past(idx)) |-> idx == $past(idx) + 4'd1);

  a_r7_valid_after_access_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(busy) && $past(cnt) == '0));

  a_r8_done_on_final_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_valid && rd_index == last_idx && req_ready));

  a_r9_base_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_q));
endmodule

// File: tb/pgsram_rd_seq_test.sv
module pgsram_rd_seq_test;
  localparam int AW = 28;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_width = 2'b00;
  logic [WW-1:0] req_first_wait = '0;
  logic [WW-1:0] req_page_wait = '0;
  logic          req_lane_pol = 1'b0;
  logic          mem_cs_n, mem_oe_n;
  logic [3:0]    mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [3:0]    rd_index;
  logic          done;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[AW-1:AW-16]};
  endfunction

  assign mem_rdata = mdata(mem_addr);

  pgsram_rd_seq #(.AW(AW), .DW(DW), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_width(req_width), .req_first_wait(req_first_wait),
    .req_page_wait(req_page_wait), .req_lane_pol(req_lane_pol),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_index(rd_index), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  localparam int NV = 6;
  localparam logic [AW-1:0] V_ADDR [NV] = '{28'h0001230, 28'h0ABCD40, 28'h0FFFF00,
                                             28'h8000010, 28'h0000050, 28'hFFFFFF0};
  localparam logic [1:0]    V_W    [NV] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10};
  localparam logic [WW-1:0] V_F    [NV] = '{4'd2, 4'd2, 4'd3, 4'd0, 4'd1, 4'd0};
  localparam logic [WW-1:0] V_P    [NV] = '{4'd1, 4'd1, 4'd0, 4'd0, 4'd2, 4'd1};
  localparam logic          V_POL  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic run_page(input logic [AW-1:0] a, input logic [1:0] w,
                          input logic [WW-1:0] f, input logic [WW-1:0] p,
                          input logic pol, input bit poke);
    logic [AW-1:0] base;
    logic [AW-1:0] ea;
    logic [AW-1:0] prev_a;
    int n, bpa, len;
    base = {a[AW-1:4], 4'b0000};
    n   = (w == 2'b00) ? 4 : (w == 2'b01) ? 8 : 16;
    bpa = (w == 2'b00) ? 4 : (w == 2'b01) ? 2 : 1;
    prev_a = '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
    req_addr = a; req_width = w; req_first_wait = f; req_page_wait = p;
    req_lane_pol = pol; req_valid = 1'b1;
    for (int k = 0; k < n; k++) begin
      len = ((k % 4) == 0) ? int'(f) + 1 : int'(p) + 1;
      ea  = base + AW'(k * bpa);
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (k == 0 && c == 0) req_valid = 1'b0;
        if (poke && k == 1 && c == 0) begin req_valid = 1'b1; req_addr = 28'h0777770; end
        if (poke && k == 2 && c == 0) req_valid = 1'b0;
        chk(mem_cs_n == 1'b0 && mem_oe_n == 1'b0, "R5 cs/oe low in page",
            {30'd0, mem_cs_n, mem_oe_n}, 32'd0);
        chk(mem_addr == ea, "R4/R3 address per clock", 32'(mem_addr), 32'(ea));
        chk(mem_be_n == (pol ? 4'b0000 : 4'b1111), "R6 byte lanes",
            32'(mem_be_n), pol ? 32'h0 : 32'hF);
        chk(req_ready == 1'b0, "R9 ready low during page", 32'(req_ready), 32'd0);
        chk(done == 1'b0, "R8 done quiet mid page", 32'(done), 32'd0);
        if (c == 0 && k > 0) begin
          chk(rd_valid == 1'b1 && rd_index == 4'(k - 1), "R7/R2 strobe and index",
              {rd_valid, 27'd0, rd_index}, {1'b1, 27'd0, 4'(k - 1)});
          chk(rd_data == mdata(prev_a), "R7 captured data", rd_data, mdata(prev_a));
        end else begin
          chk(rd_valid == 1'b0, "R7 strobe idle", 32'(rd_valid), 32'd0);
        end
      end
      prev_a = ea;
    end
    @(negedge clk);
    chk(mem_cs_n == 1'b1 && mem_oe_n == 1'b1, "R5 cs/oe released", {30'd0, mem_cs_n, mem_oe_n}, 32'd3);
    chk(mem_be_n == 4'b1111, "R6 lanes released", 32'(mem_be_n), 32'hF);
    chk(rd_valid == 1'b1 && rd_index == 4'(n - 1), "R2 final index",
        {rd_valid, 27'd0, rd_index}, {1'b1, 27'd0, 4'(n - 1)});
    chk(rd_data == mdata(prev_a), "R7 final data", rd_data, mdata(prev_a));
    chk(done == 1'b1 && req_ready == 1'b1, "R8 done with ready", {30'd0, done, req_ready}, 32'd3);
    @(negedge clk);
    chk(done == 1'b0 && rd_valid == 1'b0 && mem_cs_n == 1'b1, "R8 done one clock",
        {29'd0, done, rd_valid, mem_cs_n}, 32'd1);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_cs_n && mem_oe_n && mem_be_n == 4'hF && !rd_valid && !done,
        "R1 reset state", {25'd0, req_ready, mem_cs_n, mem_oe_n, mem_be_n == 4'hF, rd_valid, done, 1'b0},
        {25'd0, 7'b1111000});
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_cs_n == 1'b1, "R1 idle after reset", {30'd0, req_ready, mem_cs_n}, 32'd3);
    for (int i = 0; i < NV; i++)
      run_page(V_ADDR[i], V_W[i], V_F[i], V_P[i], V_POL[i], 1'b0);
    run_page(28'h0123457, 2'b00, 4'd1, 4'd0, 1'b1, 1'b0);   // R4 unaligned address
    run_page(28'h0400020, 2'b11, 4'd2, 4'd1, 1'b1, 1'b0);   // R10 width code 11
    run_page(28'h0200080, 2'b01, 4'd3, 4'd2, 1'b0, 1'b1);   // R9 request during page
    repeat (2) @(negedge clk);
    chk(mem_cs_n == 1'b1 && rd_valid == 1'b0, "R9 no extra page", {30'd0, mem_cs_n, rd_valid}, 32'd2);
    rst_n = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_cs_n == 1'b1 && done == 1'b0, "R1 reset again",
        {29'd0, req_ready, mem_cs_n, done}, 32'd6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule